// File: doc/BRIEF.md
# External Clock Presence Detector

This block watches a slow external timing clock (nominally 32 kHz) with a much faster internal reference clock and decides whether that external clock is alive. A clock that sits at a constant low level, sits at a constant high level, or runs slower than a minimum rate (about 4 kHz by default) is treated as missing. Any clock that runs at or above the minimum rate counts as present, however fast it is.

A two-bit source field picks the timing source for a downstream sequencer. One code forces the external clock, two codes force the internal clock, and one code lets the detector decide. The block produces a select level for the clock multiplexer and a read-only status bit. The status bit is meaningful only while detection is enabled, which is signalled by the upper bit of the source field. Glitch-free switching of the clocks themselves happens elsewhere.

The detector re-times the external pin into the reference domain and finds its rising edges. A gap counter restarts on each edge and flags loss when the gap grows too long. After a loss, several consecutive well-spaced edges are needed before the clock is declared present again.

Top module: `xcd_top`

## Requirements
- R1: With source field 00, `use_ext_o` is 1 whatever the state of the external clock.
- R2: With source field 01 or 11, `use_ext_o` is 0 whatever the state of the external clock.
- R3: With source field 10, `use_ext_o` equals `ext_alive_o`.
- R4: An external clock held low is reported absent (`ext_alive_o` = 0).
- R5: An external clock held high is reported absent.
- R6: A clock whose rising edges are at most GAP_LIMIT reference cycles apart (GAP_LIMIT = REF_HZ / MIN_EXT_HZ) is reported present, including clocks far faster than nominal.
- R7: A clock whose rising edges are more than GAP_LIMIT reference cycles apart is reported absent.
- R8: Out of reset, `ext_alive_o` and `status_o` are 0.
- R9: After a loss, `ext_alive_o` rises only on the LOCK_EDGES-th consecutive rising edge with in-limit spacing; fewer edges leave it 0.
- R10: `status_o` is 1 only when the source field is 10 and the external clock is present; it is 0 for every other source field.
- R11: Once the external pin stops changing, `ext_alive_o` falls within GAP_LIMIT + SYNC_STAGES + 4 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous to `clk` |
| src_mode_i | input | 2 | Source field: 00 external, 01 internal, 10 automatic, 11 internal |
| ext_alive_o | output | 1 | Detector verdict: external clock present |
| use_ext_o | output | 1 | Timing source select: 1 external, 0 internal |
| status_o | output | 1 | Read-only status: external clock detected and in use |

## Verification
The bench builds the block with REF_HZ = 40000 and MIN_EXT_HZ = 1000, so the gap limit is 40 reference cycles, with LOCK_EDGES = 3 and a two-flop synchronizer. This puts the exact rate boundary (40 versus 41 cycles per period) and the stuck-pin timeout within a few hundred cycles, and makes the three-edge requalification rule observable edge by edge. The same scaling lets a clock of period 2 stand in for a far-too-fast external clock.

// File: rtl/xcd_pkg.sv
package xcd_pkg;

   typedef enum logic [1:0] {
      SRC_EXT     = 2'b00,
      SRC_INT     = 2'b01,
      SRC_AUTO    = 2'b10,
      SRC_INT_ALT = 2'b11
   } src_mode_e;

   function automatic logic detect_on(input src_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/xcd_sync.sv
module xcd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("xcd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xcd_gap_watch.sv
module xcd_gap_watch #(
   parameter int GAP_LIMIT  = 250,
   parameter int LOCK_EDGES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic alive_o
);
   localparam int CW = $clog2(GAP_LIMIT + 1);
   localparam int LW = $clog2(LOCK_EDGES + 1);
   localparam logic [CW-1:0] GAP_MAX = CW'(GAP_LIMIT);

   if (GAP_LIMIT < 2) begin : g_bad_gap
      $error("xcd_gap_watch: GAP_LIMIT must be at least 2");
   end
   if (LOCK_EDGES < 1) begin : g_bad_lock
      $error("xcd_gap_watch: LOCK_EDGES must be at least 1");
   end

   logic          lvl_d;
   logic          rise;
   logic          expired;
   logic [CW-1:0] gap_q;
   logic          alive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl_i;
   end

   assign rise    = lvl_i & ~lvl_d;
   assign expired = (gap_q == GAP_MAX);

   // cycles since the last rising edge, saturating at the limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap_q <= GAP_MAX;
      else if (rise)     gap_q <= '0;
      else if (!expired) gap_q <= gap_q + CW'(1);
   end

   if (LOCK_EDGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       alive_q <= 1'b0;
         else if (rise)    alive_q <= ~expired;
         else if (expired) alive_q <= 1'b0;
      end
   end else begin : g_multi
      logic [LW-1:0] qual_q;
      logic [LW-1:0] qual_inc;
      assign qual_inc = qual_q + LW'(1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            alive_q <= 1'b0;
            qual_q  <= '0;
         end else if (rise) begin
            if (expired) begin
               alive_q <= 1'b0;
               qual_q  <= LW'(1);
            end else if (!alive_q) begin
               qual_q <= qual_inc;
               if (qual_inc == LW'(LOCK_EDGES)) alive_q <= 1'b1;
            end
         end else if (expired) begin
            alive_q <= 1'b0;
            qual_q  <= '0;
         end
      end
   end

   assign alive_o = alive_q;
endmodule

// File: rtl/xcd_src_sel.sv
module xcd_src_sel
   import xcd_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       alive_i,
   output logic       use_ext_o,
   output logic       status_o
);
   src_mode_e mode;
   assign mode = src_mode_e'(mode_i);

   always_comb begin
      unique case (mode)
         SRC_EXT:     use_ext_o = 1'b1;
         SRC_AUTO:    use_ext_o = alive_i;
         SRC_INT,
         SRC_INT_ALT: use_ext_o = 1'b0;
         default:     use_ext_o = 1'b0;
      endcase
   end

   assign status_o = detect_on(mode) & use_ext_o;
endmodule

// File: rtl/xcd_top.sv
module xcd_top #(
   parameter int REF_HZ      = 1000000,
   parameter int MIN_EXT_HZ  = 4000,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_EDGES  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_clk_i,
   input  logic [1:0] src_mode_i,
   output logic       ext_alive_o,
   output logic       use_ext_o,
   output logic       status_o
);
   localparam int GAP_LIMIT = REF_HZ / MIN_EXT_HZ;

   if (MIN_EXT_HZ < 1 || REF_HZ < 2 * MIN_EXT_HZ) begin : g_bad_rate
      $error("xcd_top: REF_HZ must be at least twice MIN_EXT_HZ");
   end

   logic ext_sync;

   xcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_clk_i),
      .q_o   (ext_sync)
   );

   xcd_gap_watch #(.GAP_LIMIT(GAP_LIMIT), .LOCK_EDGES(LOCK_EDGES)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (ext_sync),
      .alive_o (ext_alive_o)
   );

   xcd_src_sel u_sel (
      .mode_i    (src_mode_i),
      .alive_i   (ext_alive_o),
      .use_ext_o (use_ext_o),
      .status_o  (status_o)
   );
endmodule

// File: rtl/xcd_chk.sv
module xcd_chk #(
   parameter int QUIET_LIMIT = 256
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ext_clk_i,
   input logic [1:0] src_mode_i,
   input logic       ext_alive_o,
   input logic       use_ext_o,
   input logic       status_o
);
   localparam int QW = $clog2(QUIET_LIMIT + 1);

   logic          pin_d;
   logic [QW-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d   <= 1'b0;
         quiet_q <= '0;
      end else begin
         pin_d <= ext_clk_i;
         if (ext_clk_i != pin_d)              quiet_q <= '0;
         else if (quiet_q != QW'(QUIET_LIMIT)) quiet_q <= quiet_q + QW'(1);
      end
   end

   // R1
   force_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode_i == 2'b00) |-> use_ext_o);
   // R2
   force_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_mode_i[0] |-> !use_ext_o);
   // R3
   auto_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode_i == 2'b10) |-> (use_ext_o == ext_alive_o));
   // R10
   status_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o |-> (src_mode_i == 2'b10 && ext_alive_o));
   // R11
   quiet_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q == QW'(QUIET_LIMIT)) |-> !ext_alive_o);
   // R9
   lock_needs_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_alive_o) |-> (quiet_q < QW'(QUIET_LIMIT)));
endmodule

bind xcd_top xcd_chk #(.QUIET_LIMIT(GAP_LIMIT + SYNC_STAGES + 4)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_clk_i   (ext_clk_i),
   .src_mode_i  (src_mode_i),
   .ext_alive_o (ext_alive_o),
   .use_ext_o   (use_ext_o),
   .status_o    (status_o)
);

// File: tb/sim_xcd_top.sv
`timescale 1ns/1ps
module sim_xcd_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b10;
   logic       pat_lvl = 1'b0;
   logic       man_lvl = 1'b0;
   logic       manual = 1'b0;
   logic       ext_w;
   logic       alive, use_ext, status;
   int         hi_len = 0;
   int         lo_len = 0;
   int         ph = 0;
   int         errors = 0;
   int         checks = 0;
   logic       done = 1'b0;

   always #2.5 clk = ~clk;

   assign ext_w = manual ? man_lvl : pat_lvl;

   xcd_top #(.REF_HZ(40000), .MIN_EXT_HZ(1000), .SYNC_STAGES(2), .LOCK_EDGES(3)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_clk_i   (ext_w),
      .src_mode_i  (mode),
      .ext_alive_o (alive),
      .use_ext_o   (use_ext),
      .status_o    (status)
   );

   // pattern generator: high for hi_len cycles, low for lo_len cycles
   always begin
      @(negedge clk);
      if (hi_len == 0)      pat_lvl = 1'b0;
      else if (lo_len == 0) pat_lvl = 1'b1;
      else begin
         pat_lvl = (ph < hi_len);
         ph = ph + 1;
         if (ph >= hi_len + lo_len) ph = 0;
      end
   end

   task automatic check(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic pulse();
      man_lvl = 1'b1;
      repeat (10) @(negedge clk);
      man_lvl = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   // {mode, high cycles, low cycles, alive, use_ext, status}
   localparam int NV = 10;
   localparam logic [18:0] VEC [NV] = '{
      {2'd2, 7'd20, 7'd20, 3'b111},   // R6 period 40, at limit
      {2'd2, 7'd20, 7'd21, 3'b000},   // R7 period 41, beyond limit
      {2'd2, 7'd2,  7'd2,  3'b111},   // R6 fast clock
      {2'd3, 7'd2,  7'd2,  3'b100},   // R2 R10 forced internal, alt code
      {2'd0, 7'd0,  7'd0,  3'b010},   // R1 R4 stuck low, forced external
      {2'd1, 7'd5,  7'd5,  3'b100},   // R2 forced internal
      {2'd2, 7'd1,  7'd0,  3'b000},   // R5 stuck high
      {2'd0, 7'd10, 7'd10, 3'b110},   // R1 R10 detection off
      {2'd2, 7'd60, 7'd60, 3'b000},   // R7 slow clock
      {2'd2, 7'd1,  7'd1,  3'b111}    // R3 R6 period 2
   };

   initial begin
      repeat (5) @(negedge clk);
      check("R8 alive in reset", alive, 1'b0);
      check("R8 status in reset", status, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 alive after reset", alive, 1'b0);
      check("R3 auto select after reset", use_ext, 1'b0);

      for (int v = 0; v < NV; v++) begin
         mode   = VEC[v][18:17];
         hi_len = int'(VEC[v][16:10]);
         lo_len = int'(VEC[v][9:3]);
         ph     = 0;
         repeat (600) @(negedge clk);
         check($sformatf("R4 R5 R6 R7 alive vec %0d", v), alive,   VEC[v][2]);
         check($sformatf("R1 R2 R3 select vec %0d", v),   use_ext, VEC[v][1]);
         check($sformatf("R10 status vec %0d", v),        status,  VEC[v][0]);
      end

      // requalification edge by edge
      mode = 2'b10;
      man_lvl = 1'b0;
      manual = 1'b1;
      repeat (100) @(negedge clk);
      check("R4 held low absent", alive, 1'b0);
      pulse();
      pulse();
      repeat (5) @(negedge clk);
      check("R9 two edges not enough", alive, 1'b0);
      check("R3 auto select while unqualified", use_ext, 1'b0);
      man_lvl = 1'b1;
      repeat (10) @(negedge clk);
      check("R9 third edge qualifies", alive, 1'b1);
      check("R10 status after qualify", status, 1'b1);
      repeat (30) @(negedge clk);
      check("R11 still alive inside limit", alive, 1'b1);
      repeat (20) @(negedge clk);
      check("R5 R11 held high drops", alive, 1'b0);
      mode = 2'b00;
      @(negedge clk);
      check("R1 forced external while absent", use_ext, 1'b1);
      check("R10 status off with forced external", status, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule